// File: doc/BRIEF.md
# I2C Control Register Bank for a Dual-Output Audio/Video Switch

This block is the control side of a switch that routes one of six audio sources and one of six video sources to each of two outputs. It is an I2C slave that holds seven 8-bit control registers. The register fields leave the block as parallel outputs: mute bits, source selectors, audio attenuation codes, video gain codes, driver-mode bits and fine video gain trims. The analog side of the chip decodes these outputs.

The serial clock and data lines are sampled on a fast system clock. Each line passes through a synchronizer and a glitch filter before START, STOP and clock edges are detected. The data line is driven as open drain: the block only pulls it low or releases it. A write sends the device address, then a register index, then any number of data bytes. These bytes land at consecutive registers, and the index wraps back to 00h after the last register. Reads return data from an internal pointer. The pointer either continues from the previous access (current-address read) or is set by a write that carries only an index, followed by a repeated START (random read).

Top module: `avsw_i2c_regs`

## Requirements
- R1: While `rst_n` is low, and right after it rises, every register holds its default. All fields are zero, except the two fine video gain fields (registers 05h and 06h), which hold 5'b01010 (register value 0Ah).
- R2: The address byte is sent MSB first as 7 address bits followed by R/W (0 = write, 1 = read). The slave acknowledges only the address 7'b0010000 by pulling SDA low in the ninth clock. For any other address it acknowledges nothing and ignores the bus until the next START.
- R3: In a write, the first byte after the address loads the register pointer. Each following data byte is stored at the pointer, and the pointer then advances by one. Every byte is acknowledged.
- R4: The pointer advances from 06h, or from any higher value, to 00h. This applies to both writes and reads, so a long burst overwrites registers from 00h upward.
- R5: Bits undefined in the register map are cleared on write and read back as zero. The defined-bit masks are 00h:33h, 01h/02h/03h:77h, 04h:6Fh, 05h/06h:1Fh.
- R6: Data written at pointer values 07h and above is acknowledged but changes no register. A read at such a pointer returns 00h.
- R7: A read that follows the address byte directly returns the register at the pointer, MSB first, then advances the pointer. The pointer is kept across transactions, so each read continues from the last accessed register plus one.
- R8: A write that carries only a register index, followed by a repeated START and a read address, returns data starting at that index. The data auto-increments on each master ACK.
- R9: After the master answers a data byte with NACK, the slave releases SDA and drives nothing until the next START.
- R10: The slave changes its SDA drive only while SCL is low.
- R11: The outputs map as follows. `amute_o` = 00h[1:0] and `vmute_o` = 00h[5:4] (bit 0 belongs to output 1). The selectors and audio codes come from registers 01h, 02h and 03h: output 1 in bits [2:0], output 2 in bits [6:4]. `vgain1_o` = 04h[1:0], `vgain2_o` = 04h[3:2], `vdrv_o` = 04h[6:5]. `vfine1_o` = 05h[4:0] and `vfine2_o` = 06h[4:0].
- R12: A pulse on SCL or SDA that is shorter than `FILT_LEN` system clocks, measured after synchronization, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Active-low reset that restores the defaults |
| scl_in | input | 1 | Serial clock line as seen at the pin |
| sda_in | input | 1 | Serial data line as seen at the pin |
| sda_pull | output | 1 | 1 = pull SDA low, 0 = release |
| amute_o | output | 2 | Audio mute per output |
| vmute_o | output | 2 | Video mute per output |
| asel1_o | output | 3 | Audio source select, output 1 |
| asel2_o | output | 3 | Audio source select, output 2 |
| vsel1_o | output | 3 | Video source select, output 1 |
| vsel2_o | output | 3 | Video source select, output 2 |
| again1_o | output | 3 | Audio attenuation code, output 1 |
| again2_o | output | 3 | Audio attenuation code, output 2 |
| vgain1_o | output | 2 | Video coarse gain code, output 1 |
| vgain2_o | output | 2 | Video coarse gain code, output 2 |
| vdrv_o | output | 2 | Video driver load mode per output |
| vfine1_o | output | 5 | Video fine gain trim, output 1 |
| vfine2_o | output | 5 | Video fine gain trim, output 2 |

## Verification
The hardest states to reach are those where the pointer sits outside the defined registers, or wraps in the middle of a transfer. Reaching them takes a burst that starts near the top of the map, an index of 07h, and reads that follow each other with no index in between. The stimulus chains transactions so that each one starts from the pointer the previous one left behind, including a read burst that wraps from 06h to 00h. It also clocks a full byte after a NACK, with no START, to show that the slave stays off the bus. One write runs with single-clock SCL glitches inside every high phase.

// File: rtl/avsw_i2c_pkg.sv
package avsw_i2c_pkg;
   localparam int REG_COUNT = 7;
   localparam int IDX_W     = 8;
   localparam int FLAT_W    = REG_COUNT * 8;

   typedef enum logic [2:0] {
      L_IDLE, L_ADDR, L_ADDR_ACK, L_RX, L_RX_ACK, L_TX, L_TX_ACK, L_WAIT
   } link_state_t;

   // defined-bit mask of each register
   function automatic logic [7:0] reg_mask(input int idx);
      case (idx)
         0:       return 8'h33;
         1, 2, 3: return 8'h77;
         4:       return 8'h6F;
         5, 6:    return 8'h1F;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] reg_default(input int idx);
      return (idx == 5 || idx == 6) ? 8'h0A : 8'h00;
   endfunction

   function automatic logic [IDX_W-1:0] ptr_next(input logic [IDX_W-1:0] p);
      return (p >= IDX_W'(REG_COUNT - 1)) ? '0 : p + 1'b1;
   endfunction
endpackage

// File: rtl/avsw_i2c_in_filter.sv
module avsw_i2c_in_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   localparam int CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("avsw_i2c_in_filter: SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 1) begin : g_bad_filt
      $error("avsw_i2c_in_filter: FILT_LEN must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], d_in};
   end
   assign synced = sync_q[SYNC_STAGES-1];

   if (FILT_LEN <= 1) begin : g_nofilt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_out <= 1'b1;
         else        q_out <= synced;
      end
   end else begin : g_filt
      logic [CNT_W-1:0] run_q;
      // output follows only after FILT_LEN consecutive differing samples
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_out <= 1'b1;
            run_q <= '0;
         end else if (synced != q_out) begin
            if (run_q == CNT_W'(FILT_LEN - 1)) begin
               q_out <= synced;
               run_q <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end else begin
            run_q <= '0;
         end
      end
   end
endmodule

// File: rtl/avsw_i2c_link.sv
module avsw_i2c_link
   import avsw_i2c_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'b0010000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl,
   input  logic             sda,
   input  logic [7:0]       rd_data,
   output logic             sda_pull,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic [7:0]       wr_data,
   output logic [IDX_W-1:0] ptr
);
   link_state_t st_q;
   logic [3:0]  bits_q;
   logic [7:0]  sh_q;
   logic        rw_q, idx_seen_q, scl_p, sda_p;
   logic        scl_rise, scl_fall, bus_start, bus_stop;

   assign scl_rise  = scl & ~scl_p;
   assign scl_fall  = ~scl & scl_p;
   assign bus_start = scl & scl_p & sda_p & ~sda;
   assign bus_stop  = scl & scl_p & ~sda_p & sda;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= L_IDLE;  bits_q <= '0;  sh_q <= '0;
         rw_q <= 1'b0;    idx_seen_q <= 1'b0;
         scl_p <= 1'b1;   sda_p <= 1'b1;
         sda_pull <= 1'b0; wr_en <= 1'b0;
         wr_idx <= '0;    wr_data <= '0;  ptr <= '0;
      end else begin
         scl_p <= scl;
         sda_p <= sda;
         wr_en <= 1'b0;
         if (bus_stop) begin
            st_q     <= L_IDLE;
            sda_pull <= 1'b0;
         end else if (bus_start) begin
            st_q       <= L_ADDR;
            bits_q     <= '0;
            sda_pull   <= 1'b0;
            idx_seen_q <= 1'b0;
         end else begin
            case (st_q)
               L_ADDR, L_RX: begin
                  if (scl_rise) begin
                     sh_q   <= {sh_q[6:0], sda};
                     bits_q <= bits_q + 1'b1;
                  end else if (scl_fall && bits_q == 4'd8) begin
                     bits_q <= '0;
                     if (st_q == L_ADDR) begin
                        if (sh_q[7:1] == DEV_ADDR) begin
                           sda_pull <= 1'b1;
                           rw_q     <= sh_q[0];
                           st_q     <= L_ADDR_ACK;
                        end else begin
                           st_q <= L_WAIT;
                        end
                     end else begin
                        sda_pull <= 1'b1;
                        st_q     <= L_RX_ACK;
                        if (!idx_seen_q) begin
                           ptr        <= sh_q;
                           idx_seen_q <= 1'b1;
                        end else begin
                           wr_en   <= 1'b1;
                           wr_idx  <= ptr;
                           wr_data <= sh_q;
                           ptr     <= ptr_next(ptr);
                        end
                     end
                  end
               end
               L_ADDR_ACK, L_TX_ACK: begin
                  if (st_q == L_TX_ACK && scl_rise && sda) begin
                     st_q <= L_WAIT;                 // master NACK
                  end else if (scl_fall) begin
                     bits_q <= '0;
                     if (st_q == L_TX_ACK || rw_q) begin
                        sh_q     <= rd_data;
                        sda_pull <= ~rd_data[7];
                        ptr      <= ptr_next(ptr);
                        st_q     <= L_TX;
                     end else begin
                        sda_pull <= 1'b0;
                        st_q     <= L_RX;
                     end
                  end
               end
               L_RX_ACK: begin
                  if (scl_fall) begin
                     sda_pull <= 1'b0;
                     st_q     <= L_RX;
                  end
               end
               L_TX: begin
                  if (scl_fall) begin
                     if (bits_q == 4'd7) begin
                        sda_pull <= 1'b0;
                        st_q     <= L_TX_ACK;
                     end else begin
                        sda_pull <= ~sh_q[6];
                        sh_q     <= {sh_q[6:0], 1'b0};
                        bits_q   <= bits_q + 1'b1;
                     end
                  end
               end
               default: sda_pull <= 1'b0;
            endcase
         end
      end
   end
endmodule

// File: rtl/avsw_i2c_reg_bank.sv
module avsw_i2c_reg_bank
   import avsw_i2c_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [7:0]        wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [7:0]        rd_data,
   output logic [FLAT_W-1:0] regs_flat
);
   for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
      logic [7:0] val_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            val_q <= reg_default(g);
         else if (wr_en && wr_idx == IDX_W'(g))
            val_q <= wr_data & reg_mask(g);
      end
      assign regs_flat[g*8 +: 8] = val_q;
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < REG_COUNT; k++)
         if (rd_idx == IDX_W'(k)) rd_data = regs_flat[k*8 +: 8];
   end
endmodule

// File: rtl/avsw_i2c_regs.sv
module avsw_i2c_regs
   import avsw_i2c_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'b0010000,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_LEN    = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_in,
   input  logic       sda_in,
   output logic       sda_pull,
   output logic [1:0] amute_o,
   output logic [1:0] vmute_o,
   output logic [2:0] asel1_o,
   output logic [2:0] asel2_o,
   output logic [2:0] vsel1_o,
   output logic [2:0] vsel2_o,
   output logic [2:0] again1_o,
   output logic [2:0] again2_o,
   output logic [1:0] vgain1_o,
   output logic [1:0] vgain2_o,
   output logic [1:0] vdrv_o,
   output logic [4:0] vfine1_o,
   output logic [4:0] vfine2_o
);
   logic              scl_f, sda_f, wr_en;
   logic [IDX_W-1:0]  wr_idx, ptr;
   logic [7:0]        wr_data, rd_data;
   logic [FLAT_W-1:0] regs_flat;

   avsw_i2c_in_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) i_scl_filt (
      .clk(clk), .rst_n(rst_n), .d_in(scl_in), .q_out(scl_f));
   avsw_i2c_in_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) i_sda_filt (
      .clk(clk), .rst_n(rst_n), .d_in(sda_in), .q_out(sda_f));

   avsw_i2c_link #(.DEV_ADDR(DEV_ADDR)) i_link (
      .clk(clk), .rst_n(rst_n), .scl(scl_f), .sda(sda_f), .rd_data(rd_data),
      .sda_pull(sda_pull), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .ptr(ptr));

   avsw_i2c_reg_bank i_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(ptr), .rd_data(rd_data), .regs_flat(regs_flat));

   assign amute_o  = regs_flat[0  +: 2];
   assign vmute_o  = regs_flat[4  +: 2];
   assign asel1_o  = regs_flat[8  +: 3];
   assign asel2_o  = regs_flat[12 +: 3];
   assign vsel1_o  = regs_flat[16 +: 3];
   assign vsel2_o  = regs_flat[20 +: 3];
   assign again1_o = regs_flat[24 +: 3];
   assign again2_o = regs_flat[28 +: 3];
   assign vgain1_o = regs_flat[32 +: 2];
   assign vgain2_o = regs_flat[34 +: 2];
   assign vdrv_o   = regs_flat[37 +: 2];
   assign vfine1_o = regs_flat[40 +: 5];
   assign vfine2_o = regs_flat[48 +: 5];
endmodule

// File: rtl/avsw_i2c_regs_chk.sv
module avsw_i2c_regs_chk
   import avsw_i2c_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              scl_f,
   input logic              sda_pull,
   input logic              wr_en,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [IDX_W-1:0]  ptr,
   input logic [FLAT_W-1:0] regs_flat
);
   localparam logic [FLAT_W-1:0] DEFAULTS = {8'h0A, 8'h0A, 40'h0};

   always @(posedge clk) begin
      if (!rst_n)
         a_r1_reset_defaults: assert (regs_flat == DEFAULTS)
            else $error("R1: registers not at defaults during reset");
   end

   a_r10_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_pull != $past(sda_pull)) |-> !$past(scl_f))
      else $error("R10: SDA drive changed while SCL high");

   a_r3_ptr_advances: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx < IDX_W'(REG_COUNT - 1)) |-> ptr == wr_idx + 1'b1)
      else $error("R3: pointer did not advance after a write");

   a_r4_ptr_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx >= IDX_W'(REG_COUNT - 1)) |-> ptr == '0)
      else $error("R4: pointer did not wrap to zero");

   a_r6_high_index_discarded: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx >= IDX_W'(REG_COUNT)) |=> regs_flat == $past(regs_flat))
      else $error("R6: write above last register changed state");
endmodule

bind avsw_i2c_regs avsw_i2c_regs_chk i_chk (
   .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_pull(sda_pull), .wr_en(wr_en),
   .wr_idx(wr_idx), .ptr(ptr), .regs_flat(regs_flat));

// File: tb/test_avsw_i2c_regs.sv
module test_avsw_i2c_regs;
   localparam int CLK_NS = 10;
   localparam int QTR    = 10;   // system clocks per quarter SCL period

   logic clk = 1'b0, rst_n = 1'b1, scl_drv = 1'b1, sda_drv = 1'b1;
   logic sda_pull, sda_bus;
   logic [1:0] amute_o, vmute_o, vgain1_o, vgain2_o, vdrv_o;
   logic [2:0] asel1_o, asel2_o, vsel1_o, vsel2_o, again1_o, again2_o;
   logic [4:0] vfine1_o, vfine2_o;

   assign sda_bus = sda_drv & ~sda_pull;   // open-drain wired AND

   avsw_i2c_regs i_avsw_i2c_regs (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_bus), .sda_pull(sda_pull),
      .amute_o(amute_o), .vmute_o(vmute_o), .asel1_o(asel1_o), .asel2_o(asel2_o),
      .vsel1_o(vsel1_o), .vsel2_o(vsel2_o), .again1_o(again1_o), .again2_o(again2_o),
      .vgain1_o(vgain1_o), .vgain2_o(vgain2_o), .vdrv_o(vdrv_o),
      .vfine1_o(vfine1_o), .vfine2_o(vfine2_o));

   always #(CLK_NS/2) clk = ~clk;

   int n_checks = 0, n_errs = 0, r10_bad = 0;
   bit done = 1'b0;

   typedef struct { string tag; logic [7:0] val; } item_t;
   item_t exp_q[$];
   item_t obs_q[$];

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
      n_checks++;
      if (act !== expv) begin
         n_errs++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, expv);
      end
   endtask

   // monitor: pops observed bus results and compares against the expectations
   initial begin
      forever begin
         item_t o, e;
         wait (obs_q.size() > 0);
         o = obs_q.pop_front();
         n_checks++;
         if (exp_q.size() == 0) begin
            n_errs++;
            $display("FAIL %s: actual=%02h expected=<none>", o.tag, o.val);
         end else begin
            e = exp_q.pop_front();
            if (o.val !== e.val) begin
               n_errs++;
               $display("FAIL %s: actual=%02h expected=%02h", e.tag, o.val, e.val);
            end
         end
      end
   end

   // R10 observer: slave drive must not move while SCL is high
   logic pull_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n && scl_drv && sda_pull != pull_prev) r10_bad++;
      pull_prev = sda_pull;
   end

   task automatic qtr();
      repeat (QTR) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_drv = 1'b1; qtr(); scl_drv = 1'b1; qtr();
      sda_drv = 1'b0; qtr(); scl_drv = 1'b0; qtr();
   endtask

   task automatic bus_stop();
      sda_drv = 1'b0; qtr(); scl_drv = 1'b1; qtr();
      sda_drv = 1'b1; qtr(); qtr();
   endtask

   task automatic wbit(input logic b, input bit glitch);
      sda_drv = b; qtr(); scl_drv = 1'b1;
      if (glitch) begin
         repeat (4) @(negedge clk);
         scl_drv = 1'b0; @(negedge clk); scl_drv = 1'b1;
         repeat (15) @(negedge clk);
      end else begin
         qtr(); qtr();
      end
      scl_drv = 1'b0; qtr();
   endtask

   task automatic rbit(output logic b);
      sda_drv = 1'b1; qtr(); scl_drv = 1'b1; qtr();
      b = sda_bus; qtr(); scl_drv = 1'b0; qtr();
   endtask

   // driver: sends a byte and queues the expected acknowledge (1 = acked)
   task automatic send_byte(input logic [7:0] b, input string tag, input logic exp_ack,
                            input bit glitch = 1'b0);
      logic a;
      for (int i = 7; i >= 0; i--) wbit(b[i], glitch);
      rbit(a);
      exp_q.push_back('{tag, {7'd0, exp_ack}});
      obs_q.push_back('{tag, {7'd0, ~a}});
   endtask

   task automatic recv_byte(input logic [7:0] expv, input string tag, input bit m_ack);
      logic [7:0] d;
      logic b;
      for (int i = 7; i >= 0; i--) begin
         rbit(b);
         d[i] = b;
      end
      exp_q.push_back('{tag, expv});
      obs_q.push_back('{tag, d});
      wbit(~m_ack, 1'b0);
   endtask

   task automatic check_defaults(input string tag);
      check({tag, " amute"},  {6'd0, amute_o}, 8'h00);
      check({tag, " vmute"},  {6'd0, vmute_o}, 8'h00);
      check({tag, " sel"},    {2'd0, asel2_o, asel1_o}, 8'h00);
      check({tag, " vsel"},   {2'd0, vsel2_o, vsel1_o}, 8'h00);
      check({tag, " again"},  {2'd0, again2_o, again1_o}, 8'h00);
      check({tag, " vgain"},  {2'd0, vdrv_o, vgain2_o, vgain1_o}, 8'h00);
      check({tag, " vfine1"}, {3'd0, vfine1_o}, 8'h0A);
      check({tag, " vfine2"}, {3'd0, vfine2_o}, 8'h0A);
      check({tag, " pull"},   {7'd0, sda_pull}, 8'h00);
   endtask

   initial begin
      #1 rst_n = 1'b0;
      repeat (5) @(negedge clk);
      check_defaults("R1 in reset");
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check_defaults("R1 after release");

      // single write: reg 01h = 35h
      bus_start();
      send_byte(8'h20, "R2 addr ack", 1'b1);
      send_byte(8'h01, "R3 index ack", 1'b1);
      send_byte(8'h35, "R3 data ack", 1'b1);
      bus_stop();
      check("R11 asel1", {5'd0, asel1_o}, 8'h05);
      check("R11 asel2", {5'd0, asel2_o}, 8'h03);

      // masked write to 00h, then random read back
      bus_start();
      send_byte(8'h20, "R2 addr ack", 1'b1);
      send_byte(8'h00, "R3 index ack", 1'b1);
      send_byte(8'hFF, "R5 data ack", 1'b1);
      bus_stop();
      check("R5 amute", {6'd0, amute_o}, 8'h03);
      check("R5 vmute", {6'd0, vmute_o}, 8'h03);
      bus_start();
      send_byte(8'h20, "R8 addr ack", 1'b1);
      send_byte(8'h00, "R8 index ack", 1'b1);
      bus_start();
      send_byte(8'h21, "R8 read addr ack", 1'b1);
      recv_byte(8'h33, "R5 read back masked 00h", 1'b0);
      bus_stop();

      // burst from 05h wrapping into 00h and 01h
      bus_start();
      send_byte(8'h20, "R2 addr ack", 1'b1);
      send_byte(8'h05, "R4 index ack", 1'b1);
      send_byte(8'h13, "R4 data ack", 1'b1);
      send_byte(8'h14, "R4 data ack", 1'b1);
      send_byte(8'h01, "R4 wrap data ack", 1'b1);
      send_byte(8'h62, "R4 wrap data ack", 1'b1);
      bus_stop();
      check("R4 vfine1", {3'd0, vfine1_o}, 8'h13);
      check("R4 vfine2", {3'd0, vfine2_o}, 8'h14);
      check("R4 wrapped amute", {6'd0, amute_o}, 8'h01);
      check("R4 wrapped vmute", {6'd0, vmute_o}, 8'h00);
      check("R4 wrapped asel", {2'd0, asel2_o, asel1_o}, 8'h32);

      // burst 02h..04h
      bus_start();
      send_byte(8'h20, "R2 addr ack", 1'b1);
      send_byte(8'h02, "R3 index ack", 1'b1);
      send_byte(8'h41, "R3 data ack", 1'b1);
      send_byte(8'h26, "R3 data ack", 1'b1);
      send_byte(8'hB9, "R5 data ack", 1'b1);
      bus_stop();
      check("R11 vsel1", {5'd0, vsel1_o}, 8'h01);
      check("R11 vsel2", {5'd0, vsel2_o}, 8'h04);
      check("R11 again1", {5'd0, again1_o}, 8'h06);
      check("R11 again2", {5'd0, again2_o}, 8'h02);
      check("R11 vgain1", {6'd0, vgain1_o}, 8'h01);
      check("R11 vgain2", {6'd0, vgain2_o}, 8'h02);
      check("R11 vdrv", {6'd0, vdrv_o}, 8'h01);

      // current-address reads: pointer is 05h, read wraps 06h -> 00h
      bus_start();
      send_byte(8'h21, "R7 read addr ack", 1'b1);
      recv_byte(8'h13, "R7 current read 05h", 1'b1);
      recv_byte(8'h14, "R7 current read 06h", 1'b1);
      recv_byte(8'h01, "R4 read wraps to 00h", 1'b0);
      bus_stop();
      bus_start();
      send_byte(8'h21, "R7 read addr ack", 1'b1);
      recv_byte(8'h62, "R7 continues at 01h", 1'b0);
      bus_stop();

      // random read at 03h with auto-increment
      bus_start();
      send_byte(8'h20, "R8 addr ack", 1'b1);
      send_byte(8'h03, "R8 index ack", 1'b1);
      bus_start();
      send_byte(8'h21, "R8 read addr ack", 1'b1);
      recv_byte(8'h26, "R8 random read 03h", 1'b1);
      recv_byte(8'h29, "R8 increment 04h masked", 1'b0);
      bus_stop();

      // index 07h: discarded, then wraps to 00h
      bus_start();
      send_byte(8'h20, "R2 addr ack", 1'b1);
      send_byte(8'h07, "R6 index ack", 1'b1);
      send_byte(8'hAA, "R6 discarded data ack", 1'b1);
      send_byte(8'h10, "R6 next lands at 00h", 1'b1);
      bus_stop();
      check("R6 asel unchanged", {2'd0, asel2_o, asel1_o}, 8'h32);
      check("R6 vfine1 unchanged", {3'd0, vfine1_o}, 8'h13);
      check("R6 vfine2 unchanged", {3'd0, vfine2_o}, 8'h14);
      check("R6 00h vmute", {6'd0, vmute_o}, 8'h01);
      check("R6 00h amute", {6'd0, amute_o}, 8'h00);
      bus_start();
      send_byte(8'h20, "R8 addr ack", 1'b1);
      send_byte(8'h07, "R8 index ack", 1'b1);
      bus_start();
      send_byte(8'h21, "R8 read addr ack", 1'b1);
      recv_byte(8'h00, "R6 read at 07h", 1'b0);
      bus_stop();

      // wrong address is ignored
      bus_start();
      send_byte(8'h22, "R2 foreign addr no ack", 1'b0);
      send_byte(8'h01, "R2 ignored byte no ack", 1'b0);
      send_byte(8'h77, "R2 ignored byte no ack", 1'b0);
      bus_stop();
      check("R2 asel unchanged", {2'd0, asel2_o, asel1_o}, 8'h32);

      // NACK then extra clocks: slave stays off the bus (pointer wrapped to 00h)
      bus_start();
      send_byte(8'h21, "R7 read addr ack", 1'b1);
      recv_byte(8'h10, "R7 read 00h after wrap", 1'b0);
      recv_byte(8'hFF, "R9 released after NACK", 1'b0);
      bus_stop();

      // glitches on SCL inside every high phase
      bus_start();
      send_byte(8'h20, "R12 addr ack", 1'b1, 1'b1);
      send_byte(8'h05, "R12 index ack", 1'b1, 1'b1);
      send_byte(8'h07, "R12 data ack", 1'b1, 1'b1);
      bus_stop();
      check("R12 vfine1 after glitchy write", {3'd0, vfine1_o}, 8'h07);

      n_checks++;
      if (r10_bad != 0) begin
         n_errs++;
         $display("FAIL R10: actual=%0d changes while SCL high expected=0", r10_bad);
      end

      // reset again
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check_defaults("R1 second reset");
      rst_n = 1'b1;

      wait (obs_q.size() == 0);
      repeat (2) @(negedge clk);
      n_checks++;
      if (exp_q.size() != 0) begin
         n_errs++;
         $display("FAIL scoreboard: actual=%0d leftover expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errs++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end
endmodule